// File: doc/BRIEF.md
# Dual-Window Memory Address Decoder

This block sits in front of a memory controller on a 36-bit internal bus, where the address space is 64 GB. It compares every request address with two programmable windows. Both windows reach the same installed memory. For each request it reports which window claimed the address and gives a zero-based offset into physical memory.

The primary window holds the whole installed memory inside one aligned 4 GB region. It is normally placed in an upper region so that a full 4 GB can be used. The secondary window is optional. It always lies in the lowest 4 GB region, where address bits [35:32] are zero, and it shows the bottom part of the same memory to software that can only reach that region.

Window sizes are powers of two and are taken from one size register. A secondary window that is larger than the installed memory, or larger than 2 GB, is an illegal configuration. The block reports it on an error flag and stops decoding the secondary window. Results are registered and appear one clock after the request strobe.

Top module: `addr_win_dec`

## Requirements
- R1: A request hits the primary window when the primary window is enabled and the address bits at or above the window's size exponent equal the same bits of the primary base. Only an aligned power-of-two range is ever claimed.
- R2: The installed-size code is the 5-bit field at bits [31:27] of the size register. Code 0 disables the primary window. Code c gives 2^(19+c) bytes per bank. The bank flag at bit [2] doubles the size when it is set.
- R3: The secondary-size code is the 6-bit field at bits [21:16]. Code 0 disables the secondary window. Code s gives 2^(19+s) bytes. A secondary hit requires address bits [35:32] to be zero, and the address bits at or above the size exponent must equal the secondary base.
- R4: On a hit, the offset output is the request address with the bits at and above the window's size exponent cleared. This is the distance from the aligned base, so a secondary hit lands at the bottom of physical memory.
- R5: When both windows claim an address, only the secondary hit flag is raised and the offset is the secondary one.
- R6: An enabled secondary window whose size exceeds the installed size, exceeds 2 GB, or comes with no usable primary window raises the error flag and produces no secondary hit.
- R7: An installed size above 4 GB (exponent above 32) raises the error flag and disables the primary window.
- R8: The hit flags and offset appear one clock after a request is sampled. A cycle with the strobe low gives both hit flags low on the next cycle, and the offset holds its previous value.
- R9: While reset is asserted, both hit flags, the offset and the error flag are zero.
- R10: A request that hits neither window gives both flags low and an offset of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 36 | Request address |
| pri_base_i | input | 36 | Primary window base address |
| sec_base_i | input | 32 | Secondary window base (lowest 4 GB region) |
| size_cfg_i | input | 32 | Size register: installed code [31:27], secondary code [21:16], bank flag [2] |
| pri_hit_o | output | 1 | Registered primary hit |
| sec_hit_o | output | 1 | Registered secondary hit |
| ofs_o | output | 32 | Registered zero-based memory offset |
| cfg_err_o | output | 1 | Registered illegal-configuration flag |

## Verification
The bench builds the decoder with its default parameters: a 36-bit address, a 32-bit offset and a smallest size exponent of 20. With these values the codes that reach exactly 4 GB (code 13 alone, or code 12 with the bank flag set) can be set, and so can the 2 GB secondary cap at code 12 and the over-limit codes just above both bounds. The bench also places the primary window in the lowest region on top of a small secondary window, which exercises priority and offset selection together.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  // Field positions in the size register (decoded by software-visible layout)
  localparam int unsigned PSZ_LSB = 27;
  localparam int unsigned PSZ_W   = 5;
  localparam int unsigned SSZ_LSB = 16;
  localparam int unsigned SSZ_W   = 6;
  localparam int unsigned BANK_BIT = 2;
  // Width wide enough for any size exponent sum
  localparam int unsigned LG_W = 8;
  typedef logic [LG_W-1:0] lg_t;
endpackage

// File: rtl/addr_rst_sync.sv
module addr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/addr_size_dec.sv
module addr_size_dec
  import addr_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned MIN_LG = 20
) (
  input  logic [PSZ_W-1:0]  psz_code,
  input  logic              bank_two,
  input  logic [SSZ_W-1:0]  ssz_code,
  output logic              pri_en,
  output logic [ADDR_W-1:0] pri_mask,
  output logic              sec_en,
  output logic [ADDR_W-1:0] sec_mask,
  output logic              cfg_err
);
  localparam lg_t LG_BIAS = lg_t'(MIN_LG - 1);
  localparam lg_t LG_MAX  = lg_t'(OFS_W);
  localparam lg_t LG_CAP  = lg_t'(OFS_W - 1);

  lg_t  pri_lg, sec_lg, sec_cap;
  logic pri_req, sec_req, pri_bad, sec_bad;

  always_comb begin
    pri_req = (psz_code != '0);
    sec_req = (ssz_code != '0);
    pri_lg  = LG_BIAS + lg_t'(psz_code) + lg_t'(bank_two);
    sec_lg  = LG_BIAS + lg_t'(ssz_code);
    pri_bad = pri_req && (pri_lg > LG_MAX);
    pri_en  = pri_req && !pri_bad;
    sec_cap = (pri_lg < LG_CAP) ? pri_lg : LG_CAP;
    sec_bad = sec_req && (!pri_en || (sec_lg > sec_cap));
    sec_en  = sec_req && !sec_bad;
    cfg_err = pri_bad || sec_bad;
    pri_mask = {ADDR_W{1'b1}} << pri_lg;
    sec_mask = {ADDR_W{1'b1}} << sec_lg;
  end
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match #(
  parameter int unsigned ADDR_W   = 36,
  parameter int unsigned OFS_W    = 32,
  parameter bit          LOW_ONLY = 1'b0
) (
  input  logic              win_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  localparam int unsigned RGN_W = ADDR_W - OFS_W;

  logic rgn_ok;

  generate
    if (LOW_ONLY) begin : g_low
      assign rgn_ok = (addr[ADDR_W-1 -: RGN_W] == '0);
    end else begin : g_any
      assign rgn_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    hit = win_en && rgn_ok && (((addr ^ base) & mask) == '0);
    ofs = addr[OFS_W-1:0] & ~mask[OFS_W-1:0];
  end
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec
  import addr_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned MIN_LG = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] pri_base_i,
  input  logic [OFS_W-1:0]  sec_base_i,
  input  logic [31:0]       size_cfg_i,
  output logic              pri_hit_o,
  output logic              sec_hit_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              cfg_err_o
);
  localparam int unsigned NWIN = 2;
  localparam int unsigned PRI  = 0;
  localparam int unsigned SEC  = 1;

  logic rst_n_sync;
  logic unused_cfg;

  logic [NWIN-1:0]   win_en;
  logic [ADDR_W-1:0] win_base [NWIN];
  logic [ADDR_W-1:0] win_mask [NWIN];
  logic [NWIN-1:0]   win_hit;
  logic [OFS_W-1:0]  win_ofs  [NWIN];
  logic              cfg_err_c;

  logic             pri_hit_d, sec_hit_d, cfg_err_d;
  logic [OFS_W-1:0] ofs_d;

  assign unused_cfg = ^{size_cfg_i[PSZ_LSB-1:SSZ_LSB+SSZ_W],
                        size_cfg_i[SSZ_LSB-1:BANK_BIT+1],
                        size_cfg_i[BANK_BIT-1:0]};

  addr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  addr_size_dec #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .MIN_LG (MIN_LG)
  ) i_size_dec (
    .psz_code (size_cfg_i[PSZ_LSB +: PSZ_W]),
    .bank_two (size_cfg_i[BANK_BIT]),
    .ssz_code (size_cfg_i[SSZ_LSB +: SSZ_W]),
    .pri_en   (win_en[PRI]),
    .pri_mask (win_mask[PRI]),
    .sec_en   (win_en[SEC]),
    .sec_mask (win_mask[SEC]),
    .cfg_err  (cfg_err_c)
  );

  assign win_base[PRI] = pri_base_i;
  assign win_base[SEC] = {{(ADDR_W-OFS_W){1'b0}}, sec_base_i};

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      addr_win_match #(
        .ADDR_W   (ADDR_W),
        .OFS_W    (OFS_W),
        .LOW_ONLY (g == SEC)
      ) i_match (
        .win_en (win_en[g]),
        .addr   (req_addr_i),
        .base   (win_base[g]),
        .mask   (win_mask[g]),
        .hit    (win_hit[g]),
        .ofs    (win_ofs[g])
      );
    end
  endgenerate

  // Next-state: secondary wins on overlap
  always_comb begin
    sec_hit_d = req_valid_i && win_hit[SEC];
    pri_hit_d = req_valid_i && win_hit[PRI] && !win_hit[SEC];
    if (win_hit[SEC])      ofs_d = win_ofs[SEC];
    else if (win_hit[PRI]) ofs_d = win_ofs[PRI];
    else                   ofs_d = '0;
    cfg_err_d = cfg_err_c;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      pri_hit_o <= 1'b0;
      sec_hit_o <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      pri_hit_o <= pri_hit_d;
      sec_hit_o <= sec_hit_d;
      cfg_err_o <= cfg_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)      ofs_o <= '0;
    else if (req_valid_i) ofs_o <= ofs_d;
  end
endmodule

// File: rtl/addr_win_dec_chk.sv
module addr_win_dec_chk #(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned OFS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              pri_hit_o,
  input logic              sec_hit_o,
  input logic [OFS_W-1:0]  ofs_o,
  input logic              cfg_err_o
);
  // R5
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_hit_o && sec_hit_o));

  // R8
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!pri_hit_o && !sec_hit_o));

  // R8
  idle_ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> $stable(ofs_o));

  // R3
  sec_low_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (!sec_hit_o || ($past(req_addr_i[ADDR_W-1:OFS_W]) == '0)));

  // R6
  sec_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hit_o |-> !cfg_err_o);

  // R6
  sec_ofs_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hit_o |-> !ofs_o[OFS_W-1]);
endmodule

bind addr_win_dec addr_win_dec_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .pri_hit_o   (pri_hit_o),
  .sec_hit_o   (sec_hit_o),
  .ofs_o       (ofs_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/test_addr_win_dec.sv
module test_addr_win_dec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [35:0] req_addr_i;
  logic [35:0] pri_base_i;
  logic [31:0] sec_base_i;
  logic [31:0] size_cfg_i;
  logic        pri_hit_o, sec_hit_o, cfg_err_o;
  logic [31:0] ofs_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] model_ofs = '0;

  typedef struct {
    logic        pri;
    logic        sec;
    logic [31:0] ofs;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;

  addr_win_dec i_addr_win_dec (
    .clk (clk), .rst_n (rst_n), .req_valid_i (req_valid_i),
    .req_addr_i (req_addr_i), .pri_base_i (pri_base_i),
    .sec_base_i (sec_base_i), .size_cfg_i (size_cfg_i),
    .pri_hit_o (pri_hit_o), .sec_hit_o (sec_hit_o),
    .ofs_o (ofs_o), .cfg_err_o (cfg_err_o)
  );

  function automatic logic [31:0] mk_cfg(int pc, bit bk, int sc);
    logic [4:0] p = pc[4:0];
    logic [5:0] s = sc[5:0];
    return {p, 5'b0, s, 13'b0, bk, 2'b0};
  endfunction

  // Reference built from the requirement text
  function automatic exp_t model(logic [35:0] a, logic v, string tag);
    exp_t e;
    int pc  = int'(size_cfg_i[31:27]);
    int bk  = int'(size_cfg_i[2]);
    int sc  = int'(size_cfg_i[21:16]);
    int plg = 19 + pc + bk;
    int slg = 19 + sc;
    int cap = (plg < 31) ? plg : 31;
    bit pok  = (pc != 0) && (plg <= 32);
    bit pbad = (pc != 0) && (plg > 32);
    bit sbad = (sc != 0) && (!pok || slg > cap);
    longint unsigned au = 64'(a);
    longint unsigned pb = 64'(pri_base_i);
    longint unsigned sb = 64'(sec_base_i);
    e.sec = v && (sc != 0) && !sbad && ((au >> 32) == 0) && ((au >> slg) == (sb >> slg));
    e.pri = v && pok && !e.sec && ((au >> plg) == (pb >> plg));
    if (v) begin
      if (e.sec)      model_ofs = 32'(au & ((64'd1 << slg) - 1));
      else if (e.pri) model_ofs = 32'(au & ((64'd1 << plg) - 1));
      else            model_ofs = '0;
    end
    e.ofs = model_ofs;
    e.err = pbad || sbad;
    e.tag = tag;
    return e;
  endfunction

  task automatic set_cfg(logic [35:0] pb, logic [31:0] sb, logic [31:0] sz);
    @(negedge clk);
    pri_base_i = pb;
    sec_base_i = sb;
    size_cfg_i = sz;
  endtask

  task automatic drive(logic [35:0] a, logic v, string tag);
    exp_t e;
    @(negedge clk);
    req_addr_i  = a;
    req_valid_i = v;
    e = model(a, v, tag);
    @(posedge clk);
    sb_q.push_back(e);
  endtask

  // Monitor: compare one result per cycle after its request
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (pri_hit_o !== e.pri || sec_hit_o !== e.sec || ofs_o !== e.ofs || cfg_err_o !== e.err) begin
        bad++;
        $display("FAIL %s: got pri=%b sec=%b ofs=%h err=%b exp pri=%b sec=%b ofs=%h err=%b",
                 e.tag, pri_hit_o, sec_hit_o, ofs_o, cfg_err_o, e.pri, e.sec, e.ofs, e.err);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid_i = 1'b0; req_addr_i = '0;
    pri_base_i = '0; sec_base_i = '0; size_cfg_i = mk_cfg(13, 0, 12);
    req_addr_i = 36'h0_0000_0100;
    repeat (3) @(negedge clk);
    // R9: outputs zero while reset is held
    total++;
    if ({pri_hit_o, sec_hit_o, cfg_err_o} !== 3'b0 || ofs_o !== '0) begin
      bad++;
      $display("FAIL R9: got pri=%b sec=%b ofs=%h err=%b exp all zero",
               pri_hit_o, sec_hit_o, ofs_o, cfg_err_o);
    end
    size_cfg_i = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: both windows off
    drive(36'h0_0000_0100, 1, "R2 disabled");
    drive(36'h3_1234_5678, 1, "R2 disabled hi");

    // R1 R4: 4 GB primary in region 3
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(13, 0, 0));
    drive(36'h3_1234_5678, 1, "R1 R4 pri hit");
    drive(36'h3_FFFF_FFFF, 1, "R4 pri top");
    drive(36'h2_1234_5678, 1, "R10 region below");
    drive(36'h4_0000_0000, 1, "R10 region above");
    // R2: bank flag doubles
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(12, 1, 0));
    drive(36'h3_9000_0004, 1, "R2 bank doubled");
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(12, 0, 0));
    drive(36'h3_9000_0004, 1, "R2 single bank miss");
    drive(36'h3_7000_0004, 1, "R2 single bank hit");

    // R3: 2 GB secondary at low base, primary high
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(13, 0, 12));
    drive(36'h0_7FFF_FFFF, 1, "R3 sec top");
    drive(36'h0_8000_0000, 1, "R3 sec beyond");
    drive(36'h1_0000_0010, 1, "R3 upper bits set");
    // R3 R4: 16 MB secondary
    set_cfg(36'h3_0000_0000, 32'h4000_0000, mk_cfg(13, 0, 5));
    drive(36'h0_4012_3456, 1, "R3 R4 sec small");
    drive(36'h1_4012_3456, 1, "R3 alias above low region");

    // R5: overlap, primary in low region
    set_cfg(36'h0_0000_0000, 32'h4000_0000, mk_cfg(13, 0, 5));
    drive(36'h0_4000_0010, 1, "R5 overlap sec wins");
    drive(36'h0_5000_0000, 1, "R5 pri outside sec");

    // R8: idle cycles hold offset, drop hits
    drive(36'h0_4000_0010, 0, "R8 idle");
    drive(36'h0_5000_0000, 0, "R8 idle again");
    drive(36'h0_4000_0020, 1, "R8 resume");

    // R6: cap at 2 GB
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(13, 0, 13));
    drive(36'h0_0000_0040, 1, "R6 over 2GB");
    // R6: cap at installed size
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(5, 0, 6));
    drive(36'h0_0000_0040, 1, "R6 over installed");
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(5, 0, 5));
    drive(36'h0_0000_0040, 1, "R6 equal installed");
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(0, 0, 3));
    drive(36'h0_0000_0040, 1, "R6 no primary");

    // R7: installed over 4 GB
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(13, 1, 0));
    drive(36'h3_0000_0040, 1, "R7 over 4GB bank");
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(14, 0, 0));
    drive(36'h3_0000_0040, 1, "R7 over 4GB code");

    // R10: miss clears offset
    set_cfg(36'h3_0000_0000, 32'h0, mk_cfg(13, 0, 0));
    drive(36'h3_0000_0ABC, 1, "R10 hit before miss");
    drive(36'h5_0000_0ABC, 1, "R10 miss zero offset");

    drive(36'h0, 0, "R8 drain");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule